// File: doc/BRIEF.md
# Routed Interrupt Controller with Core-by-Pin Steering

This block collects 32 peripheral interrupt lines and steers each one to a chosen processor core and a chosen interrupt pin on that core. Each line is configured for level or edge sensing and for its active polarity. A line's status bit is latched when the line is active, and a per-line enable decides whether that status counts as pending. Only pending lines reach the outputs.

Every line owns one routing byte. The low nibble is a one-hot choice of core (cores 0 to 3) and the high nibble is a one-hot choice of pin (pins 0 to 3). The outputs form a 4x4 matrix, `irqOut[core*4 + pin]`. Each output is the OR of every pending line whose routing byte selects that core and that pin.

Software reaches the block through a plain 32-bit register port. It supplies a word address (byte offset divided by four), write data, byte strobes and a write enable. Read data is combinational from the word address. The raw lines pass through a two-flop synchronizer before the block senses them.

Top module: `irq_steer_top`

## Requirements
- R1: After reset, the enable, polarity and edge masks and all routing bytes read zero, and every output is low.
- R2: The routing byte of source s sits at byte offset s, so it is in word s/4, byte lane s%4. Words 0 to 7 are read and written as 32-bit words, and a write changes only the byte lanes whose strobe is 1.
- R3: `irqOut[c*4+p]` is high when at least one source is pending and its routing byte has bit c and bit 4+p set. A byte with an empty nibble routes nowhere, and a byte with several bits set routes to every core and pin pair it selects.
- R4: Writing 1s to offset 0x28 sets those enable bits, and writing 1s to offset 0x2C clears them. Zero bits and byte lanes that are not strobed have no effect. Offset 0x24 reads back the enable mask.
- R5: A source whose edge bit is 0 is level sensed. With polarity 1 its status is high while the synchronized input is 1, and with polarity 0 its status is high while the input is 0. Status reads at offset 0x20.
- R6: A source whose edge bit is 1 sets its status on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The status then holds until a 1 is written to that bit at offset 0x20.
- R7: A source is pending only when both its status bit and its enable bit are 1. Clearing the enable removes the source from the outputs but leaves its latched status as it was.
- R8: A change on an input reaches the outputs on the third rising clock edge after it is applied (two synchronizer flops, then the status register).
- R9: The polarity mask at offset 0x30 and the edge mask at offset 0x38 are read-write, with byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busWordAddr | input | 6 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte strobes for the write |
| busRdData | output | 32 | Read data for the addressed word |
| irqIn | input | 32 | Raw interrupt lines |
| irqOut | output | 16 | Interrupt matrix, index core*4+pin |

## Verification
The routing table is tested with single-core single-pin bytes on every core and every pin, with a byte that selects two cores and two pins at once, and with a byte whose pin nibble is empty. These cases separate a correct AND of the two nibbles from an OR or a swapped index. Directed cases drive each of the four trigger encodings. A level source must release its output when its input goes back to idle, and an edge source must hold its output until it is cleared. The opposite edge must leave an edge source untouched. Disabling a source must block its output while keeping its status, and the output is sampled one cycle before and at the expected edge to pin down the latency.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NUM_SRC = 32;
  localparam int NUM_CORE = 4;
  localparam int NUM_PIN = 4;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;
  localparam int WADDR_W = 6;
  localparam int ROUTE_WORDS = NUM_SRC / LANES;
  localparam int ROUTE_IDX_W = $clog2(ROUTE_WORDS);
  localparam int NUM_OUT = NUM_CORE * NUM_PIN;

  localparam logic [WADDR_W-1:0] W_STAT  = 6'h08;
  localparam logic [WADDR_W-1:0] W_ENRD  = 6'h09;
  localparam logic [WADDR_W-1:0] W_ENSET = 6'h0A;
  localparam logic [WADDR_W-1:0] W_ENCLR = 6'h0B;
  localparam logic [WADDR_W-1:0] W_POL   = 6'h0C;
  localparam logic [WADDR_W-1:0] W_EDGE  = 6'h0E;

  typedef enum logic [2:0] {
    RD_NONE, RD_ROUTE, RD_STAT, RD_EN, RD_POL, RD_EDGE
  } rdSel_e;

  typedef struct packed {
    logic [ROUTE_WORDS-1:0] wrRoute;
    logic                   wrStat;
    logic                   wrEnSet;
    logic                   wrEnClr;
    logic                   wrPol;
    logic                   wrEdge;
    logic [DATA_W-1:0]      data;
    logic [DATA_W-1:0]      beMask;
    logic [DATA_W-1:0]      bitMask;
    rdSel_e                 rdSel;
    logic [ROUTE_IDX_W-1:0] routeIdx;
  } strobe_t;
endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic               busWrEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [LANES-1:0]   busBe,
  output strobe_t            str
);

  always_comb begin
    str = '0;
    str.data = busWdata;
    for (int b = 0; b < LANES; b++) begin
      str.beMask[b*8 +: 8] = {8{busBe[b]}};
    end
    str.bitMask = busWdata & str.beMask;
    str.rdSel = RD_NONE;
    str.routeIdx = busWordAddr[ROUTE_IDX_W-1:0];
    if (busWordAddr < WADDR_W'(ROUTE_WORDS)) begin
      str.rdSel = RD_ROUTE;
      str.wrRoute[busWordAddr[ROUTE_IDX_W-1:0]] = busWrEn;
    end else begin
      case (busWordAddr)
        W_STAT: begin
          str.rdSel = RD_STAT;
          str.wrStat = busWrEn;
        end
        W_ENRD:  str.rdSel = RD_EN;
        W_ENSET: str.wrEnSet = busWrEn;
        W_ENCLR: str.wrEnClr = busWrEn;
        W_POL: begin
          str.rdSel = RD_POL;
          str.wrPol = busWrEn;
        end
        W_EDGE: begin
          str.rdSel = RD_EDGE;
          str.wrEdge = busWrEn;
        end
        default: str.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            str,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_OUT-1:0] irqOut
);

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] syncOut, lastQ;
  logic [NUM_SRC-1:0] enQ, polQ, edgeQ, statQ;
  logic [NUM_SRC-1:0] activeLvl, edgeHit, clrMask, statNext, pend;
  logic [7:0]         routeQ [NUM_SRC];

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      lastQ <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      lastQ <= syncOut;
    end
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // trigger evaluation
  assign activeLvl = ~(syncOut ^ polQ);
  assign edgeHit   = (polQ & syncOut & ~lastQ) | (~polQ & ~syncOut & lastQ);
  assign clrMask   = str.wrStat ? str.bitMask : '0;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      if (edgeQ[s]) statNext[s] = (statQ[s] & ~clrMask[s]) | edgeHit[s];
      else          statNext[s] = activeLvl[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enQ   <= '0;
      polQ  <= '0;
      edgeQ <= '0;
    end else begin
      statQ <= statNext;
      if (str.wrEnSet) enQ <= enQ | str.bitMask;
      else if (str.wrEnClr) enQ <= enQ & ~str.bitMask;
      if (str.wrPol)  polQ  <= (polQ & ~str.beMask) | str.bitMask;
      if (str.wrEdge) edgeQ <= (edgeQ & ~str.beMask) | str.bitMask;
    end
  end

  // routing byte storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) routeQ[s] <= '0;
    end else begin
      for (int w = 0; w < ROUTE_WORDS; w++) begin
        for (int b = 0; b < LANES; b++) begin
          if (str.wrRoute[w] && str.beMask[b*8]) routeQ[w*LANES+b] <= str.data[b*8 +: 8];
        end
      end
    end
  end

  assign pend = statQ & enQ;

  // core-by-pin output matrix
  for (genvar c = 0; c < NUM_CORE; c++) begin : gCore
    for (genvar p = 0; p < NUM_PIN; p++) begin : gPin
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
          hit = hit | (pend[s] & routeQ[s][c] & routeQ[s][NUM_CORE+p]);
        end
      end
      assign irqOut[c*NUM_PIN+p] = hit;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (str.rdSel)
      RD_ROUTE: begin
        for (int b = 0; b < LANES; b++) begin
          rdData[b*8 +: 8] = routeQ[int'(str.routeIdx)*LANES+b];
        end
      end
      RD_STAT: rdData = statQ;
      RD_EN:   rdData = enQ;
      RD_POL:  rdData = polQ;
      RD_EDGE: rdData = edgeQ;
      default: rdData = '0;
    endcase
  end

  // R4: set strobe leaves the selected enables at one
  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEnSet |=> ((enQ & $past(str.bitMask)) == $past(str.bitMask)));

  // R4: clear strobe leaves the selected enables at zero
  a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEnClr |=> ((enQ & $past(str.bitMask)) == '0));

  // R5: level sources track the polarity-adjusted synchronized input
  a_r5_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((statQ ^ $past(activeLvl)) & ~$past(edgeQ)) == '0));

  // R6: a latched edge status is only dropped by a write-one-to-clear
  a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(statQ & edgeQ & ~clrMask) & ~statQ) == '0));

  // R7: no output without a pending source
  a_r7_out_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> ((statQ & enQ) != '0));

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [LANES-1:0]   busBe,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_OUT-1:0] irqOut
);

  strobe_t str;

  irq_steer_ctrl u_ctrl (
    .busWrEn    (busWrEn),
    .busWordAddr(busWordAddr),
    .busWdata   (busWdata),
    .busBe      (busBe),
    .str        (str)
  );

  irq_steer_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .str   (str),
    .irqIn (irqIn),
    .rdData(busRdData),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_irq_steer_top.sv
`timescale 1ns/1ps
module sim_irq_steer_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdData;
  logic [31:0] irqIn = '0;
  logic [15:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] polShadow = '0;
  logic [31:0] edgeShadow = '0;
  logic [31:0] rd;

  // {source, routing byte, expected irqOut}
  localparam logic [28:0] VEC [8] = '{
    {5'd0,  8'h11, 16'h0001},
    {5'd5,  8'h21, 16'h0002},
    {5'd13, 8'h82, 16'h0080},
    {5'd31, 8'h48, 16'h4000},
    {5'd20, 8'h14, 16'h0100},
    {5'd7,  8'h33, 16'h0033},
    {5'd9,  8'h0F, 16'h0000},
    {5'd16, 8'h88, 16'h8000}
  };

  always #5 clk = ~clk;

  irq_steer_top u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busBe(busBe), .busRdData(busRdData),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busWordAddr = a; busWdata = d; busBe = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busWordAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setRoute(input int s, input logic [7:0] r);
    busWrite(6'(s / 4), {4{r}}, 4'(1 << (s % 4)));
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(4);

    // R1 reset state
    #1 check("R1 outputs", {16'h0, irqOut}, 32'h0);
    busRead(6'h09, rd); check("R1 enable", rd, 32'h0);
    busRead(6'h0C, rd); check("R1 polarity", rd, 32'h0);
    busRead(6'h0E, rd); check("R1 edge", rd, 32'h0);
    busRead(6'h03, rd); check("R1 route", rd, 32'h0);
    // R5 level-low default: idle inputs read active
    busRead(6'h08, rd); check("R5 status level-low idle", rd, 32'hFFFF_FFFF);

    // R2 byte strobes on routing words
    busWrite(6'h00, 32'h4433_2211, 4'hF);
    busWrite(6'h00, 32'hAAAA_AAAA, 4'b0010);
    busRead(6'h00, rd); check("R2 byte lane", rd, 32'h4433_AA11);
    busWrite(6'h00, 32'h0, 4'hF);

    // R4 enable set/clear
    busWrite(6'h0A, 32'h0000_00F0, 4'hF);
    busRead(6'h09, rd); check("R4 set", rd, 32'h0000_00F0);
    busWrite(6'h0A, 32'h0, 4'hF);
    busRead(6'h09, rd); check("R4 set zero no effect", rd, 32'h0000_00F0);
    busWrite(6'h0B, 32'h0000_0030, 4'hF);
    busRead(6'h09, rd); check("R4 clear", rd, 32'h0000_00C0);
    busWrite(6'h0A, 32'hFFFF_FFFF, 4'b0001);
    busRead(6'h09, rd); check("R4 byte strobe", rd, 32'h0000_00FF);
    busWrite(6'h0B, 32'hFFFF_FFFF, 4'hF);
    busRead(6'h09, rd); check("R4 clear all", rd, 32'h0);

    // R9 polarity and edge readback with strobes
    busWrite(6'h0C, 32'h1234_5678, 4'b0101);
    busRead(6'h0C, rd); check("R9 polarity", rd, 32'h0034_0078);
    busWrite(6'h0C, 32'h0, 4'hF);
    busWrite(6'h0E, 32'hA5A5_A5A5, 4'b1000);
    busRead(6'h0E, rd); check("R9 edge", rd, 32'hA500_0000);
    busWrite(6'h0E, 32'h0, 4'hF);

    // R3 routing matrix, level-high sources
    for (int i = 0; i < 8; i++) begin
      int s;
      s = int'(VEC[i][28:24]);
      polShadow[s] = 1'b1;
      busWrite(6'h0C, polShadow, 4'hF);
      setRoute(s, VEC[i][23:16]);
      busWrite(6'h0A, 32'(1) << s, 4'hF);
      irqIn[s] = 1'b1;
      waitCyc(4);
      check($sformatf("R3 route src%0d", s), {16'h0, irqOut}, {16'h0, VEC[i][15:0]});
      irqIn[s] = 1'b0;
      waitCyc(4);
      check($sformatf("R5 level-high release src%0d", s), {16'h0, irqOut}, 32'h0);
      busWrite(6'h0B, 32'(1) << s, 4'hF);
      setRoute(s, 8'h00);
    end

    // R5 level-low, source 3
    setRoute(3, 8'h11);
    busWrite(6'h0A, 32'h8, 4'hF);
    #1 check("R5 level-low idle active", {16'h0, irqOut}, 32'h0001);
    irqIn[3] = 1'b1;
    waitCyc(4);
    check("R5 level-low inactive", {16'h0, irqOut}, 32'h0);
    irqIn[3] = 1'b0;
    waitCyc(4);
    check("R5 level-low active again", {16'h0, irqOut}, 32'h0001);
    busWrite(6'h0B, 32'h8, 4'hF);
    setRoute(3, 8'h00);

    // R6 rising edge, source 10
    polShadow[10] = 1'b1; edgeShadow[10] = 1'b1;
    busWrite(6'h0C, polShadow, 4'hF);
    busWrite(6'h0E, edgeShadow, 4'hF);
    busWrite(6'h08, 32'(1) << 10, 4'hF);
    setRoute(10, 8'h12);
    busWrite(6'h0A, 32'(1) << 10, 4'hF);
    #1 check("R6 rising idle", {16'h0, irqOut}, 32'h0);
    irqIn[10] = 1'b1;
    waitCyc(4);
    check("R6 rising set", {16'h0, irqOut}, 32'h0010);
    irqIn[10] = 1'b0;
    waitCyc(4);
    check("R6 rising sticky", {16'h0, irqOut}, 32'h0010);
    busRead(6'h08, rd); check("R6 status bit10", rd & 32'h400, 32'h400);
    busWrite(6'h08, 32'(1) << 10, 4'hF);
    #1 check("R6 write-one-clear", {16'h0, irqOut}, 32'h0);

    // R6 falling edge, source 11
    edgeShadow[11] = 1'b1;
    busWrite(6'h0E, edgeShadow, 4'hF);
    busWrite(6'h08, 32'(1) << 11, 4'hF);
    setRoute(11, 8'h81);
    busWrite(6'h0A, 32'(1) << 11, 4'hF);
    irqIn[11] = 1'b1;
    waitCyc(4);
    check("R6 falling ignores rise", {16'h0, irqOut}, 32'h0);
    irqIn[11] = 1'b0;
    waitCyc(4);
    check("R6 falling set", {16'h0, irqOut}, 32'h0008);

    // R7 enable gating keeps status
    busWrite(6'h0B, 32'(1) << 11, 4'hF);
    #1 check("R7 disabled output", {16'h0, irqOut}, 32'h0);
    busRead(6'h08, rd); check("R7 status kept", rd & 32'h800, 32'h800);
    busWrite(6'h0A, 32'(1) << 11, 4'hF);
    #1 check("R7 re-enabled output", {16'h0, irqOut}, 32'h0008);
    busWrite(6'h08, 32'(1) << 11, 4'hF);
    busWrite(6'h0B, 32'(1) << 11, 4'hF);
    setRoute(11, 8'h00);

    // R8 latency, source 20 level-high
    setRoute(20, 8'h14);
    busWrite(6'h0A, 32'(1) << 20, 4'hF);
    irqIn[20] = 1'b1;
    waitCyc(2);
    check("R8 not before third edge", {16'h0, irqOut}, 32'h0);
    waitCyc(1);
    check("R8 at third edge", {16'h0, irqOut}, 32'h0100);
    irqIn[20] = 1'b0;
    waitCyc(2);
    check("R8 release not early", {16'h0, irqOut}, 32'h0100);
    waitCyc(1);
    check("R8 release at third edge", {16'h0, irqOut}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule